// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Idle and Break Insertion

This block turns parallel characters into an asynchronous serial stream. Software writes a character into a one-deep holding register. From there the character moves into a shift register that drives the line one bit per bit-rate tick. While one character is on the wire, the next one can wait in the holding register, so consecutive characters leave with no idle gap between them. The bit-rate tick is a one-cycle pulse from an external divider; this block generates no baud rate of its own.

Two control inputs change what goes on the wire at the next word boundary:

- **Transmit enable.**
  - Dropping it and raising it again queues one idle word, which is a preamble of all-ones bit times.
  - Each time it rises, one bit time passes before any word can start.
- **Break request.**
  - While it is held high, break words repeat back to back.
  - Releasing it queues one final break.

When several words are pending at a boundary, the idle word goes first, then the break, then data. An output-enable signal drops when both the transmit and receive enables are low, which hands the pin back to general-purpose use.

Top module: `async_tx`

## Requirements
- R1: While reset is active and after it is released, `txd` is 1, `dr_empty` is 1 and `tx_done` is 1.
- R2: A data word is, in this order: one start bit of 0, the DATA_W data bits with bit 0 first, and one stop bit of 1. `txd` changes only in the cycle after a clock edge at which `bit_tick` is 1, and each bit lasts exactly one tick interval.
- R3: A write strobe makes `dr_empty` 0 on the next cycle. `dr_empty` returns to 1 on the cycle after the held character moves into the shifter. A character written while another is shifting starts on the tick that ends the earlier stop bit, so there is no idle bit between them.
- R4: `tx_done` is 1 exactly when all of these hold: the shifter is idle, the holding register is empty, and no idle word or break is pending or requested.
- R5: On a clock edge where `tx_en` is first seen high, and on the next tick after it, no word is started.
- R6: A falling edge on `tx_en` queues one idle word of DATA_W+2 bit times at 1. It is sent at the first word boundary at which `tx_en` is high.
- R7: While `brk_req` is 1 and `tx_en` is 1, break words repeat back to back. Each break word is DATA_W+2 bit times at 0 followed by one bit time at 1.
- R8: A falling edge on `brk_req` queues exactly one further break word.
- R9: At a word boundary the pending work is served in this order: idle word first, then break (queued or requested), then the held data character. Only one item starts per boundary.
- R10: `txd_oe` is 1 when `tx_en` or `rx_en` is 1, and 0 when both are 0.
- R11: A word already shifting completes when `tx_en` goes low. While `tx_en` is 0, no new word starts and `txd` stays at 1 once the shifter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable; only affects pin ownership |
| brk_req | input | 1 | Break request |
| dr_wr | input | 1 | Write strobe for the transmit holding register |
| dr_wdata | input | DATA_W | Character to transmit |
| txd | output | 1 | Serial line, idles at 1 |
| txd_oe | output | 1 | Pin drive enable |
| dr_empty | output | 1 | Holding register empty |
| tx_done | output | 1 | Transmitter fully idle |

## Verification
The bench builds the block with DATA_W = 8 and a bit tick every fourth clock. With such short bit times, the following all fit in a few thousand cycles:

- back-to-back characters;
- repeated and trailing breaks;
- a boundary at which an idle word, a break and a character are all pending together.

The tick phase drifts against the control edges that the bench drives. This brings within reach an enable rise that lands on a tick cycle and a boundary that falls while the enable is low.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  // What the shifter is told to load at a word boundary
  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_PRE  = 2'd1,
    WK_BRK  = 2'd2,
    WK_DATA = 2'd3
  } word_kind_e;
endpackage

// File: rtl/async_tx_hold.sv
module async_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              hold_valid,
  output logic [DATA_W-1:0] hold_data
);
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q,  data_d;

  // a write in the same cycle as a take refills the register
  always_comb begin
    valid_d = valid_q;
    data_d  = data_q;
    if (take)  valid_d = 1'b0;
    if (wr_en) begin
      valid_d = 1'b1;
      data_d  = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
    end
  end

  assign hold_valid = valid_q;
  assign hold_data  = data_q;
endmodule

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl
  import async_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       tx_en,
  input  logic       brk_req,
  input  logic       at_boundary,
  input  logic       hold_valid,
  output word_kind_e load_kind,
  output logic       pend_pre,
  output logic       pend_brk
);
  logic en_q, brk_q, guard_q, pre_q, pbrk_q;
  logic en_d, brk_d, guard_d, pre_d, pbrk_d;
  logic en_rise, en_fall, brk_fall, load_ok;

  assign en_rise  = tx_en & ~en_q;
  assign en_fall  = ~tx_en & en_q;
  assign brk_fall = ~brk_req & brk_q;
  // a fresh enable holds off loading for one full tick
  assign load_ok  = at_boundary & tx_en & ~guard_q & ~en_rise;

  always_comb begin
    load_kind = WK_NONE;
    if (load_ok) begin
      if (pre_q)                 load_kind = WK_PRE;
      else if (brk_req | pbrk_q) load_kind = WK_BRK;
      else if (hold_valid)       load_kind = WK_DATA;
    end
  end

  always_comb begin
    en_d    = tx_en;
    brk_d   = brk_req;
    guard_d = en_rise | (guard_q & ~bit_tick);
    pre_d   = en_fall | (pre_q & (load_kind != WK_PRE));
    pbrk_d  = brk_fall | (pbrk_q & (load_kind != WK_BRK));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      brk_q   <= 1'b0;
      guard_q <= 1'b0;
      pre_q   <= 1'b0;
      pbrk_q  <= 1'b0;
    end else begin
      en_q    <= en_d;
      brk_q   <= brk_d;
      guard_q <= guard_d;
      pre_q   <= pre_d;
      pbrk_q  <= pbrk_d;
    end
  end

  assign pend_pre = pre_q;
  assign pend_brk = pbrk_q;
endmodule

// File: rtl/async_tx_shift.sv
module async_tx_shift
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  word_kind_e        load_kind,
  input  logic [DATA_W-1:0] load_data,
  output logic              line,
  output logic              busy,
  output logic              at_boundary
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] WORD_CNT = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] BRK_CNT  = CNT_W'(DATA_W + 3);

  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [CNT_W-1:0]   cnt_q,   cnt_d;

  assign busy        = (cnt_q != '0);
  assign at_boundary = bit_tick & (cnt_q <= CNT_W'(1));

  always_comb begin
    frame_d = frame_q;
    cnt_d   = cnt_q;
    if (bit_tick && busy) begin
      frame_d = {1'b1, frame_q[FRAME_W-1:1]};
      cnt_d   = cnt_q - CNT_W'(1);
    end
    unique case (load_kind)
      WK_DATA: begin
        frame_d = {2'b11, load_data, 1'b0};
        cnt_d   = WORD_CNT;
      end
      WK_PRE: begin
        frame_d = '1;
        cnt_d   = WORD_CNT;
      end
      WK_BRK: begin
        frame_d = {1'b1, {(FRAME_W-1){1'b0}}};
        cnt_d   = BRK_CNT;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      cnt_q   <= '0;
    end else begin
      frame_q <= frame_d;
      cnt_q   <= cnt_d;
    end
  end

  assign line = busy ? frame_q[0] : 1'b1;
endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              brk_req,
  input  logic              dr_wr,
  input  logic [DATA_W-1:0] dr_wdata,
  output logic              txd,
  output logic              txd_oe,
  output logic              dr_empty,
  output logic              tx_done
);
  word_kind_e        load_kind;
  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic              pend_pre, pend_brk;
  logic              shift_busy, at_boundary, line;

  async_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (dr_wr),
    .wr_data    (dr_wdata),
    .take       (load_kind == WK_DATA),
    .hold_valid (hold_valid),
    .hold_data  (hold_data)
  );

  async_tx_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .tx_en       (tx_en),
    .brk_req     (brk_req),
    .at_boundary (at_boundary),
    .hold_valid  (hold_valid),
    .load_kind   (load_kind),
    .pend_pre    (pend_pre),
    .pend_brk    (pend_brk)
  );

  async_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .load_kind   (load_kind),
    .load_data   (hold_data),
    .line        (line),
    .busy        (shift_busy),
    .at_boundary (at_boundary)
  );

  assign txd      = line;
  assign txd_oe   = tx_en | rx_en;
  assign dr_empty = ~hold_valid;
  assign tx_done  = ~shift_busy & hold_valid == 1'b0 & ~pend_pre & ~pend_brk & ~brk_req;
endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic tx_en,
  input logic dr_wr,
  input logic txd,
  input logic dr_empty,
  input logic tx_done,
  input logic busy
);
  // R2
  line_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd));
  // R3
  write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dr_wr |=> !dr_empty);
  // R3
  fill_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dr_empty) |-> $past(dr_wr));
  // R4
  done_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> txd);
  // R5
  enable_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_en) && !busy) |=> txd);
  // R11
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !busy) |=> txd);
endmodule

bind async_tx async_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_tick (bit_tick),
  .tx_en    (tx_en),
  .dr_wr    (dr_wr),
  .txd      (txd),
  .dr_empty (dr_empty),
  .tx_done  (tx_done),
  .busy     (shift_busy)
);

// File: tb/async_tx_tb.sv
module async_tx_tb;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic tx_en = 1'b0, rx_en = 1'b0, brk_req = 1'b0, dr_wr = 1'b0;
  logic [DW-1:0] dr_wdata = '0;
  logic txd, txd_oe, dr_empty, tx_done;

  int n_chk = 0, n_fail = 0;
  string phase = "R1";
  bit finished = 1'b0;

  always #5 clk = ~clk;

  async_tx #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en), .rx_en(rx_en),
    .brk_req(brk_req), .dr_wr(dr_wr), .dr_wdata(dr_wdata), .txd(txd),
    .txd_oe(txd_oe), .dr_empty(dr_empty), .tx_done(tx_done));

  // tick every fourth clock
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    bit_tick <= (tdiv == 0);
  end

  // behavioural reference: bits still to send, pending work
  bit mq[$];
  bit m_hv, m_pre, m_pbrk, m_guard, m_enq, m_brkq;
  logic [DW-1:0] m_hd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      m_hv = 0; m_pre = 0; m_pbrk = 0; m_guard = 0; m_enq = 0; m_brkq = 0; m_hd = '0;
    end else begin
      bit rise, fall, bfall, bound;
      rise  = tx_en && !m_enq;
      fall  = !tx_en && m_enq;
      bfall = m_brkq && !brk_req;
      bound = bit_tick && (mq.size() <= 1);
      if (bit_tick && mq.size() > 0) void'(mq.pop_front());
      if (bound && tx_en && !m_guard && !rise) begin
        if (m_pre) begin
          for (int i = 0; i < DW + 2; i++) mq.push_back(1'b1);
          m_pre = 0;
        end else if (brk_req || m_pbrk) begin
          for (int i = 0; i < DW + 2; i++) mq.push_back(1'b0);
          mq.push_back(1'b1);
          m_pbrk = 0;
        end else if (m_hv) begin
          mq.push_back(1'b0);
          for (int i = 0; i < DW; i++) mq.push_back(m_hd[i]);
          mq.push_back(1'b1);
          m_hv = 0;
        end
      end
      if (dr_wr) begin m_hd = dr_wdata; m_hv = 1; end
      if (fall)  m_pre = 1;
      if (bfall) m_pbrk = 1;
      m_guard = rise ? 1'b1 : (bit_tick ? 1'b0 : m_guard);
      m_enq = tx_en;
      m_brkq = brk_req;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // cycle compare against the reference, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit e_txd, e_done;
      e_txd  = (mq.size() > 0) ? mq[0] : 1'b1;
      e_done = (mq.size() == 0) && !m_hv && !m_pre && !m_pbrk && !brk_req;
      chk(txd == e_txd, phase, "txd", int'(txd), int'(e_txd));
      chk(dr_empty == !m_hv, "R3", "dr_empty", int'(dr_empty), int'(!m_hv));
      chk(tx_done == e_done, "R4", "tx_done", int'(tx_done), int'(e_done));
      chk(txd_oe == (tx_en | rx_en), "R10", "txd_oe", int'(txd_oe), int'(tx_en | rx_en));
    end
  end

  // line value after each tick
  bit tick_seen = 1'b0;
  bit lg[$];
  always @(posedge clk) tick_seen <= bit_tick;
  always @(negedge clk) if (rst_n && tick_seen) lg.push_back(txd);

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic write_dr(input logic [DW-1:0] d);
    @(negedge clk); #1;
    dr_wr = 1'b1; dr_wdata = d;
    @(negedge clk); #1;
    dr_wr = 1'b0;
  endtask

  task automatic wait_done();
    int k = 0;
    cyc(2);
    while (!tx_done && k < 3000) begin cyc(1); k++; end
    chk(tx_done == 1'b1, phase, "idle reached", int'(tx_done), 1);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired in %s", phase);
    summary();
  end

  initial begin
    // R1 reset state
    cyc(3);
    chk(txd == 1'b1 && dr_empty && tx_done, "R1", "txd/empty/done in reset",
        int'({txd, dr_empty, tx_done}), 7);
    rst_n = 1'b1;
    cyc(2);
    chk(txd == 1'b1 && dr_empty && tx_done, "R1", "after release",
        int'({txd, dr_empty, tx_done}), 7);

    // R11 no word while disabled, R10 pin owned by receiver enable
    phase = "R11";
    rx_en = 1'b1;
    write_dr(8'h5A);
    cyc(1);
    chk(tx_done == 1'b0, "R11", "held data pending", int'(tx_done), 0);
    for (int i = 0; i < 30; i++) begin
      cyc(1);
      chk(txd == 1'b1, "R11", "line quiet while disabled", int'(txd), 1);
    end
    chk(txd_oe == 1'b1, "R10", "oe with rx only", int'(txd_oe), 1);
    rx_en = 1'b0;
    cyc(1);
    chk(txd_oe == 1'b0, "R10", "oe released", int'(txd_oe), 0);

    // R5 delayed start, R2 frame
    phase = "R5";
    lg.delete();
    tx_en = 1'b1;
    wait_done();
    phase = "R2";
    begin
      int s = -1; logic [DW-1:0] got; bit stp;
      for (int i = 0; i < lg.size(); i++) if (s < 0 && lg[i] == 1'b0) s = i;
      chk(s >= 1, "R5", "idle tick before start", s, 1);
      if (s >= 0 && s + DW + 1 < lg.size()) begin
        for (int b = 0; b < DW; b++) got[b] = lg[s + 1 + b];
        stp = lg[s + DW + 1];
        chk(got == 8'h5A, "R2", "decoded data", int'(got), 'h5A);
        chk(stp == 1'b1, "R2", "stop bit", int'(stp), 1);
      end else chk(1'b0, "R2", "frame captured", s, 0);
    end

    // R3 back to back
    phase = "R3";
    write_dr(8'h3C);
    cyc(1);
    chk(dr_empty == 1'b0, "R3", "empty cleared by write", int'(dr_empty), 0);
    while (!dr_empty) cyc(1);
    write_dr(8'hC3);
    wait_done();

    // R6 preamble after current word
    phase = "R6";
    write_dr(8'h55);
    while (!dr_empty) cyc(1);
    cyc(3);
    tx_en = 1'b0; cyc(1); tx_en = 1'b1;
    wait_done();

    // R7 continuous break, R8 trailing break
    phase = "R7";
    lg.delete();
    brk_req = 1'b1;
    cyc(130);
    begin
      int s = -1, run = 0;
      for (int i = 0; i < lg.size(); i++) if (s < 0 && lg[i] == 1'b0) s = i;
      for (int i = (s < 0 ? lg.size() : s); i < lg.size() && lg[i] == 1'b0; i++) run++;
      chk(run == DW + 2, "R7", "break low run", run, DW + 2);
    end
    phase = "R8";
    brk_req = 1'b0;
    wait_done();

    // R9 preamble, break and data all pending
    phase = "R9";
    write_dr(8'h0F);
    while (!dr_empty) cyc(1);
    write_dr(8'hF0);
    brk_req = 1'b1; cyc(1); brk_req = 1'b0;
    tx_en = 1'b0; cyc(1); tx_en = 1'b1;
    wait_done();

    // enable rise landing on varied tick phases
    phase = "R5";
    for (int p = 0; p < 4; p++) begin
      tx_en = 1'b0; cyc(3 + p);
      write_dr(8'h81 + 8'(p));
      tx_en = 1'b1;
      wait_done();
    end

    summary();
  end
endmodule